// File: doc/BRIEF.md
# Microcontroller-to-DSP Command Mailbox

This block moves one command byte and one 16-bit data word from a microcontroller clock domain into a DSP clock domain. The two clocks are unrelated. The microcontroller fills three byte slots: slot 0 holds the command, slot 1 holds the data high byte and slot 2 holds the data low byte. Writing slot 0 is the commit. It takes the new slot 0 byte together with the current slot 1 and slot 2 bytes as one snapshot. A toggle handshake carries that snapshot across, and the DSP side loads its command and data registers from it in a single cycle. The DSP therefore never sees a command from one commit paired with data from another.

The DSP reads its two registers over a 16-bit read port. On that port the command comes back zero-extended. The DSP reads the command first and the data second. From the command read until the data read, the read-side state machine holds off any update. While the DSP is powered off, a commit waits in the crossing and is delivered as soon as power returns. The microcontroller sees a busy flag from a commit until the DSP side has acknowledged it. A commit written while busy replaces any snapshot still waiting its turn.

Top module: `mcu_dsp_mailbox`

## Requirements
- R1: After reset, `m_busy` is 0, a command read returns 0x0000 and a data read returns 0x0000.
- R2: Writes to slot 1 or slot 2 (`m_wr_idx` = 1 or 2) change nothing that the DSP reads until slot 0 is written.
- R3: A write to slot 0 (`m_wr_idx` = 0) commits a snapshot in which the command is the byte written, data bits 15:8 are slot 1 and data bits 7:0 are slot 2.
- R4: A read with `d_rd_sel` = 0 returns the command in bits 7:0 with bits 15:8 zero. A read with `d_rd_sel` = 1 returns the data word.
- R5: `m_busy` is 1 in the microcontroller cycle after a commit. It stays 1 until the snapshot has been loaded on the DSP side and the acknowledge has returned.
- R6: A commit issued while `m_busy` is 1 overwrites any waiting snapshot. After the block goes idle, the DSP holds the most recent commit.
- R7: After a command read (`d_rd_en` = 1 with `d_rd_sel` = 0), the DSP registers do not change until a data read completes the pair. The data read returns the word that belongs to the command just read.
- R8: While `d_power_on` is 0, the DSP registers hold their values and `m_busy` stays 1 for a pending commit. Once `d_power_on` returns to 1, the pending snapshot is delivered.
- R9: Slot bytes persist across commits. A commit that rewrites only slot 0 reuses the earlier slot 1 and slot 2 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Microcontroller clock |
| m_rst_n | input | 1 | Microcontroller-domain asynchronous reset, active low |
| m_wr_en | input | 1 | Slot write strobe |
| m_wr_idx | input | 2 | Slot index: 0 = command (commit), 1 = data high, 2 = data low |
| m_wr_byte | input | 8 | Byte to write |
| m_busy | output | 1 | A commit is still in flight or waiting |
| d_clk | input | 1 | DSP clock |
| d_rst_n | input | 1 | DSP-domain asynchronous reset, active low |
| d_power_on | input | 1 | DSP powered; deliveries occur only while 1 |
| d_rd_en | input | 1 | DSP read strobe |
| d_rd_sel | input | 1 | 0 = command register, 1 = data register |
| d_rd_word | output | 16 | Read data (combinational from the selected register) |

## Verification
The bench sweeps a series of commits with arithmetically generated bytes and checks that every read pair returns that commit's command and data. A design that latched on slot 1 or slot 2 writes, or took stale data bytes, would fail here. It starts a commit after a command read but before the data read. A design that did not fence updates during a read pair would return a new data word with the old command. It sends back-to-back commits to show that the last one wins and that an overwrite neither drops the latest snapshot nor tears it. It also holds the DSP powered off across a commit. A design that delivered while off would change the registers early, and one that lost the snapshot would never clear `m_busy`.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // DSP read-pair tracking
   typedef enum logic {
      RD_IDLE = 1'b0,
      RD_OPEN = 1'b1
   } rd_state_e;

   // DSP read selector encoding
   localparam logic SEL_CMD  = 1'b0;
   localparam logic SEL_DATA = 1'b1;

   // Slot indices on the microcontroller side
   localparam logic [1:0] SLOT_CMD = 2'd0;
   localparam logic [1:0] SLOT_HI  = 2'd1;
   localparam logic [1:0] SLOT_LO  = 2'd2;
endpackage

// File: rtl/mbx_toggle_sync.sv
module mbx_toggle_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("mbx_toggle_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/mbx_mcu_side.sv
module mbx_mcu_side
   import mbx_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int SNAP_W = 3 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_idx,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              ack_sync,
   output logic              req_tgl,
   output logic [SNAP_W-1:0] hold,
   output logic              busy
);
   logic [BYTE_W-1:0] slot_hi, slot_lo;
   logic [SNAP_W-1:0] pend;
   logic              pend_v;
   logic              outstanding;
   logic              commit;
   logic [SNAP_W-1:0] snap;

   assign outstanding = (req_tgl != ack_sync);
   assign commit      = wr_en && (wr_idx == SLOT_CMD);
   assign snap        = {wr_byte, slot_hi, slot_lo};
   assign busy        = outstanding || pend_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_hi <= '0;
         slot_lo <= '0;
      end else if (wr_en) begin
         if (wr_idx == SLOT_HI) slot_hi <= wr_byte;
         if (wr_idx == SLOT_LO) slot_lo <= wr_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_tgl <= 1'b0;
         hold    <= '0;
         pend    <= '0;
         pend_v  <= 1'b0;
      end else if (!outstanding) begin
         if (commit) begin
            hold    <= snap;
            req_tgl <= ~req_tgl;
            pend_v  <= 1'b0;
         end else if (pend_v) begin
            hold    <= pend;
            req_tgl <= ~req_tgl;
            pend_v  <= 1'b0;
         end
      end else if (commit) begin
         pend   <= snap;
         pend_v <= 1'b1;
      end
   end

   AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> busy); // R5

   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_tgl != $past(req_tgl)) |-> ($past(ack_sync) == $past(req_tgl))); // R6

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (outstanding && $past(outstanding) && (req_tgl == $past(req_tgl))) |-> $stable(hold)); // R3
endmodule

// File: rtl/mbx_dsp_side.sv
module mbx_dsp_side
   import mbx_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int SNAP_W = 3 * BYTE_W,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              power_on,
   input  logic              req_sync,
   input  logic [SNAP_W-1:0] hold,
   input  logic              rd_en,
   input  logic              rd_sel,
   output logic [WORD_W-1:0] rd_word,
   output logic              ack_tgl
);
   rd_state_e         state;
   logic [BYTE_W-1:0] cmd_r;
   logic [WORD_W-1:0] data_r;
   logic              cmd_rd, data_rd;
   logic              load;

   assign cmd_rd  = rd_en && (rd_sel == SEL_CMD);
   assign data_rd = rd_en && (rd_sel == SEL_DATA);
   // Load only when a new toggle is seen, power is on and no pair is open or opening
   assign load    = (req_sync != ack_tgl) && power_on && (state == RD_IDLE) && !cmd_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_r   <= '0;
         data_r  <= '0;
         ack_tgl <= 1'b0;
      end else if (load) begin
         cmd_r   <= hold[SNAP_W-1 -: BYTE_W];
         data_r  <= hold[WORD_W-1:0];
         ack_tgl <= req_sync;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= RD_IDLE;
      else begin
         case (state)
            RD_IDLE: if (cmd_rd)  state <= RD_OPEN;
            RD_OPEN: if (data_rd) state <= RD_IDLE;
            default:              state <= RD_IDLE;
         endcase
      end
   end

   assign rd_word = (rd_sel == SEL_DATA) ? data_r : {{(WORD_W-BYTE_W){1'b0}}, cmd_r};

   AST_PAIR_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RD_OPEN) |=> ($stable(cmd_r) && $stable(data_r))); // R7

   AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !power_on |=> ($stable(cmd_r) && $stable(data_r) && $stable(ack_tgl))); // R8

   AST_ACK_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_tgl != $past(ack_tgl)) |-> $past(power_on)); // R8
endmodule

// File: rtl/mcu_dsp_mailbox.sv
module mcu_dsp_mailbox #(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  m_clk,
   input  logic                  m_rst_n,
   input  logic                  m_wr_en,
   input  logic [1:0]            m_wr_idx,
   input  logic [BYTE_W-1:0]     m_wr_byte,
   output logic                  m_busy,
   input  logic                  d_clk,
   input  logic                  d_rst_n,
   input  logic                  d_power_on,
   input  logic                  d_rd_en,
   input  logic                  d_rd_sel,
   output logic [2*BYTE_W-1:0]   d_rd_word
);
   localparam int SNAP_W = 3 * BYTE_W;

   generate
      if (BYTE_W < 1) begin : g_bad_w
         $error("mcu_dsp_mailbox: BYTE_W must be positive");
      end
   endgenerate

   logic              req_tgl, req_sync;
   logic              ack_tgl, ack_sync;
   logic [SNAP_W-1:0] hold;

   mbx_mcu_side #(.BYTE_W(BYTE_W)) u_mcu (
      .clk(m_clk), .rst_n(m_rst_n),
      .wr_en(m_wr_en), .wr_idx(m_wr_idx), .wr_byte(m_wr_byte),
      .ack_sync(ack_sync), .req_tgl(req_tgl), .hold(hold), .busy(m_busy)
   );

   mbx_toggle_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(d_clk), .rst_n(d_rst_n), .din(req_tgl), .dout(req_sync)
   );

   mbx_toggle_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(m_clk), .rst_n(m_rst_n), .din(ack_tgl), .dout(ack_sync)
   );

   mbx_dsp_side #(.BYTE_W(BYTE_W)) u_dsp (
      .clk(d_clk), .rst_n(d_rst_n), .power_on(d_power_on),
      .req_sync(req_sync), .hold(hold),
      .rd_en(d_rd_en), .rd_sel(d_rd_sel), .rd_word(d_rd_word),
      .ack_tgl(ack_tgl)
   );
endmodule

// File: tb/mcu_dsp_mailbox_test.sv
module mcu_dsp_mailbox_test;
   logic        m_clk = 1'b0, d_clk = 1'b0;
   logic        m_rst_n = 1'b0, d_rst_n = 1'b0;
   logic        m_wr_en = 1'b0;
   logic [1:0]  m_wr_idx = 2'd0;
   logic [7:0]  m_wr_byte = 8'd0;
   logic        m_busy;
   logic        d_power_on = 1'b1;
   logic        d_rd_en = 1'b0;
   logic        d_rd_sel = 1'b0;
   logic [15:0] d_rd_word;

   int checks = 0, errors = 0;
   bit done = 0;

   always #5 m_clk = ~m_clk;
   always #7 d_clk = ~d_clk;

   mcu_dsp_mailbox uut (
      .m_clk(m_clk), .m_rst_n(m_rst_n), .m_wr_en(m_wr_en), .m_wr_idx(m_wr_idx),
      .m_wr_byte(m_wr_byte), .m_busy(m_busy),
      .d_clk(d_clk), .d_rst_n(d_rst_n), .d_power_on(d_power_on),
      .d_rd_en(d_rd_en), .d_rd_sel(d_rd_sel), .d_rd_word(d_rd_word)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic mwrite(input logic [1:0] idx, input logic [7:0] b);
      @(negedge m_clk);
      m_wr_en = 1'b1; m_wr_idx = idx; m_wr_byte = b;
      @(negedge m_clk);
      m_wr_en = 1'b0;
   endtask

   task automatic dread(input logic sel, output logic [15:0] v);
      @(negedge d_clk);
      d_rd_en = 1'b1; d_rd_sel = sel;
      #1 v = d_rd_word;
      @(negedge d_clk);
      d_rd_en = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      while (m_busy && n < 400) begin
         @(negedge m_clk);
         n++;
      end
      check(req, {15'd0, m_busy}, 16'd0);
      repeat (3) @(negedge d_clk);
   endtask

   task automatic read_pair(input string req, input logic [15:0] ecmd, input logic [15:0] edata);
      logic [15:0] v;
      dread(1'b0, v); check(req, v, ecmd);
      dread(1'b1, v); check(req, v, edata);
   endtask

   initial begin
      #1500000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic [7:0] c, h, l;
      repeat (4) @(negedge m_clk);
      m_rst_n = 1'b1; d_rst_n = 1'b1;
      repeat (2) @(negedge m_clk);

      // R1 reset state
      check("R1 busy", {15'd0, m_busy}, 16'd0);
      read_pair("R1", 16'h0000, 16'h0000);

      // R3/R4 sweep of commits
      for (int i = 0; i < 24; i++) begin
         c = 8'(i * 37 + 5); h = 8'(i * 11 + 128); l = 8'(~i);
         mwrite(2'd1, h);
         mwrite(2'd2, l);
         mwrite(2'd0, c);
         check("R5 busy after commit", {15'd0, m_busy}, 16'd1);
         wait_idle("R5 idle");
         read_pair("R3 R4", {8'h00, c}, {h, l});
      end

      // R2 slot 1/2 writes alone do nothing visible
      mwrite(2'd1, 8'hA5);
      mwrite(2'd2, 8'h5A);
      repeat (40) @(negedge m_clk);
      check("R2 busy", {15'd0, m_busy}, 16'd0);
      read_pair("R2", {8'h00, c}, {h, l});
      // R9 slot bytes persist
      mwrite(2'd0, 8'h3C);
      wait_idle("R9 idle");
      read_pair("R9", 16'h003C, 16'hA55A);
      mwrite(2'd0, 8'hC3);
      wait_idle("R9 idle2");
      read_pair("R9 reuse", 16'h00C3, 16'hA55A);

      // R6 back-to-back commits, last wins
      mwrite(2'd1, 8'h11); mwrite(2'd2, 8'h22);
      mwrite(2'd0, 8'h01);
      mwrite(2'd1, 8'h33);
      mwrite(2'd0, 8'h02);
      mwrite(2'd2, 8'h44);
      mwrite(2'd0, 8'h03);
      check("R6 busy", {15'd0, m_busy}, 16'd1);
      wait_idle("R6 idle");
      read_pair("R6", 16'h0003, 16'h3344);

      // R7 commit while a read pair is open
      dread(1'b0, v); check("R7 cmd", v, 16'h0003);
      mwrite(2'd1, 8'h77); mwrite(2'd2, 8'h88); mwrite(2'd0, 8'h99);
      repeat (60) @(negedge m_clk);
      check("R7 busy held", {15'd0, m_busy}, 16'd1);
      dread(1'b1, v); check("R7 data", v, 16'h3344);
      wait_idle("R7 idle");
      read_pair("R7 new", 16'h0099, 16'h7788);

      // R8 power-off deferral
      @(negedge d_clk); d_power_on = 1'b0;
      mwrite(2'd1, 8'hDE); mwrite(2'd2, 8'hAD); mwrite(2'd0, 8'hBE);
      repeat (60) @(negedge m_clk);
      check("R8 busy off", {15'd0, m_busy}, 16'd1);
      read_pair("R8 held", 16'h0099, 16'h7788);
      @(negedge d_clk); d_power_on = 1'b1;
      wait_idle("R8 idle");
      read_pair("R8 delivered", 16'h00BE, 16'hDEAD);

      // R4 data read without a preceding command read
      dread(1'b1, v); check("R4 data only", v, 16'hDEAD);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule